// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects interrupt requests for a small processor core and decides, at each instruction boundary, whether to divert the core into a service routine and which vector to use. Sources come in two kinds, chosen per source by a parameter. A latched source records its trigger in a flag that persists until the routine is entered or software clears it. A level source has no flag and requests service only while its input line is high.

The core drives one-cycle strobes for enable-interrupts, disable-interrupts and return-from-interrupt instructions, plus a retire strobe at each instruction boundary. Disabling takes effect in the same cycle. Enabling and returning open a one-instruction window in which nothing is taken. Software writes a mask of local enables and clears flags by writing ones. The controller answers with a single-cycle take pulse and the vector index.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A trigger pulse on a latched source sets its flag on the next clock edge, whatever the local and global enables hold. If a trigger and a clearing write hit the same flag in one cycle, the flag ends up set.
- R2: When a latched source is taken, its flag reads zero after the next edge, unless a new trigger for it arrived in the take cycle.
- R3: A clearing write (`clr_we_i` high) clears every flag whose bit in `clr_mask_i` is 1 and leaves every flag whose bit is 0 unchanged.
- R4: A level source (bit set in `LEVEL_SRC`; default sources 6 and 7) never shows a flag and is taken only in a cycle where its line is high and enabled. If the line falls before the global enable opens, nothing is taken.
- R5: Among requesting sources (flag set or level high, and locally enabled), source 0 has the highest priority. `vec_o` carries the lowest requesting index while `take_o` is high, and pending sources are served one per take.
- R6: In a cycle with `cli_i` high, `take_o` is low, even if a request arrives in that cycle. The global enable reads zero from the next edge on.
- R7: `sei_i` sets the global enable. No take occurs in the strobe cycle. If the strobe comes without `retire_i`, the first later retire is also blocked. The next retire after that may take.
- R8: `reti_i` sets the global enable under the same one-instruction shadow as R7.
- R9: `take_o` is high for one cycle, only together with `retire_i` while the global enable is set. It clears the global enable at the next edge.
- R10: Reset clears all flags, all local enables, the global enable and the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | Trigger pulses for latched sources |
| lvl_i | input | N_SRC | Condition lines for level sources |
| en_we_i | input | 1 | Write strobe for the local enable mask |
| en_wdata_i | input | N_SRC | New local enable mask |
| clr_we_i | input | 1 | Write strobe for flag clearing |
| clr_mask_i | input | N_SRC | Ones mark flags to clear |
| sei_i | input | 1 | Enable-interrupts strobe |
| cli_i | input | 1 | Disable-interrupts strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| retire_i | input | 1 | Instruction boundary strobe |
| take_o | output | 1 | Take-interrupt pulse |
| vec_o | output | IDX_W | Vector index of the taken source, zero otherwise |
| flags_o | output | N_SRC | Flag readback |
| gie_o | output | 1 | Global enable |

## Verification
Two functions meet in one cycle. A trigger can land on a flag in the same cycle as a clearing write or a hardware acknowledge. A disable, enable or return strobe can coincide with a retire boundary while a request is pending. Directed sequences force each such collision on purpose: an event together with a ones-write, a disable together with a retire and a pending flag, and enable strobes both with and without a retire. Random traffic sets many strobes at once. Every cycle, the outputs are compared with an independent model of the requirements, which treats the disable as winning over the enable and the trigger as winning over the clear.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   // Core-side control strobes grouped for the gating stage.
   typedef struct packed {
      logic sei;
      logic cli;
      logic reti;
      logic retire;
   } core_strobe_t;

   localparam int unsigned MAX_SRC = 32;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned      N_SRC     = 8,
   parameter logic [N_SRC-1:0] LEVEL_SRC = N_SRC'(8'hC0),
   localparam int unsigned     IDX_W     = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_i,
   input  logic [N_SRC-1:0] lvl_i,
   input  logic             en_we_i,
   input  logic [N_SRC-1:0] en_wdata_i,
   input  logic             clr_we_i,
   input  logic [N_SRC-1:0] clr_mask_i,
   input  logic             ack_i,
   input  logic [IDX_W-1:0] ack_idx_i,
   output logic [N_SRC-1:0] flags_o,
   output logic [N_SRC-1:0] en_o,
   output logic [N_SRC-1:0] req_o
);
   logic [N_SRC-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (en_we_i) en_q <= en_wdata_i;
   end

   assign en_o = en_q;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (LEVEL_SRC[i]) begin : g_level
         assign flags_o[i] = 1'b0;
         assign req_o[i]   = lvl_i[i] & en_q[i];
      end else begin : g_latched
         logic flag_q;
         logic drop;
         assign drop = (clr_we_i & clr_mask_i[i]) |
                       (ack_i & (ack_idx_i == IDX_W'(i)));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (evt_i[i]) flag_q <= 1'b1;
            else if (drop)     flag_q <= 1'b0;
         end
         assign flags_o[i] = flag_q;
         assign req_o[i]   = flag_q & en_q[i];
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned  N_SRC     = 8,
   parameter bit           LOW_FIRST = 1'b1,
   localparam int unsigned IDX_W     = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0] req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   assign any_o = |req_i;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         idx_o = '0;
         for (int k = N_SRC - 1; k >= 0; k--) begin
            if (req_i[k]) idx_o = IDX_W'(k);
         end
      end
   end else begin : g_high
      always_comb begin
         idx_o = '0;
         for (int k = 0; k < N_SRC; k++) begin
            if (req_i[k]) idx_o = IDX_W'(k);
         end
      end
   end
endmodule

// File: rtl/irq_gate_ctl.sv
module irq_gate_ctl
   import prio_irq_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  core_strobe_t strb_i,
   input  logic         any_req_i,
   output logic         take_o,
   output logic         gie_o
);
   logic gie_q;
   logic shadow_q;
   logic opening;

   assign opening = strb_i.sei | strb_i.reti;

   always_comb begin
      take_o = strb_i.retire & gie_q & ~strb_i.cli & ~opening &
               ~shadow_q & any_req_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q    <= 1'b0;
         shadow_q <= 1'b0;
      end else begin
         if (strb_i.cli)   gie_q <= 1'b0;
         else if (take_o)  gie_q <= 1'b0;
         else if (opening) gie_q <= 1'b1;

         if (opening && !strb_i.retire) shadow_q <= 1'b1;
         else if (strb_i.retire)         shadow_q <= 1'b0;
      end
   end

   assign gie_o = gie_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int unsigned      N_SRC     = 8,
   parameter logic [N_SRC-1:0] LEVEL_SRC = N_SRC'(8'hC0),
   parameter bit               LOW_FIRST = 1'b1,
   localparam int unsigned     IDX_W     = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_i,
   input  logic [N_SRC-1:0] lvl_i,
   input  logic             en_we_i,
   input  logic [N_SRC-1:0] en_wdata_i,
   input  logic             clr_we_i,
   input  logic [N_SRC-1:0] clr_mask_i,
   input  logic             sei_i,
   input  logic             cli_i,
   input  logic             reti_i,
   input  logic             retire_i,
   output logic             take_o,
   output logic [IDX_W-1:0] vec_o,
   output logic [N_SRC-1:0] flags_o,
   output logic             gie_o
);
   if (N_SRC < 2 || N_SRC > MAX_SRC) begin : g_bad_n
      $error("prio_irq_ctrl: N_SRC out of range");
   end

   logic [N_SRC-1:0] en_q;
   logic [N_SRC-1:0] req;
   logic             any_req;
   logic [IDX_W-1:0] pick;
   core_strobe_t     strb;

   assign strb = '{sei: sei_i, cli: cli_i, reti: reti_i, retire: retire_i};

   irq_flag_bank #(.N_SRC(N_SRC), .LEVEL_SRC(LEVEL_SRC)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .lvl_i      (lvl_i),
      .en_we_i    (en_we_i),
      .en_wdata_i (en_wdata_i),
      .clr_we_i   (clr_we_i),
      .clr_mask_i (clr_mask_i),
      .ack_i      (take_o),
      .ack_idx_i  (pick),
      .flags_o    (flags_o),
      .en_o       (en_q),
      .req_o      (req)
   );

   irq_prio_pick #(.N_SRC(N_SRC), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req_i (req),
      .any_o (any_req),
      .idx_o (pick)
   );

   irq_gate_ctl u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .strb_i    (strb),
      .any_req_i (any_req),
      .take_o    (take_o),
      .gie_o     (gie_o)
   );

   assign vec_o = take_o ? pick : '0;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int unsigned      N_SRC     = 8,
   parameter logic [N_SRC-1:0] LEVEL_SRC = N_SRC'(8'hC0),
   localparam int unsigned     IDX_W     = $clog2(N_SRC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] evt_i,
   input logic [N_SRC-1:0] lvl_i,
   input logic             clr_we_i,
   input logic [N_SRC-1:0] clr_mask_i,
   input logic             sei_i,
   input logic             cli_i,
   input logic             reti_i,
   input logic             retire_i,
   input logic             take_o,
   input logic [IDX_W-1:0] vec_o,
   input logic [N_SRC-1:0] flags_o,
   input logic             gie_o,
   input logic [N_SRC-1:0] en_q
);
   localparam logic [N_SRC-1:0] LATCHED = ~LEVEL_SRC;

   logic [N_SRC-1:0] want;
   logic [N_SRC-1:0] below;

   assign want  = ((flags_o & LATCHED) | (lvl_i & LEVEL_SRC)) & en_q;
   assign below = (N_SRC'(1) << vec_o) - N_SRC'(1);

   AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_i & LATCHED)) |=> ((flags_o & $past(evt_i & LATCHED)) == $past(evt_i & LATCHED))); // R1
   AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && !LEVEL_SRC[vec_o] && !evt_i[vec_o]) |=> !flags_o[$past(vec_o)]); // R2
   AST_W1C_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && !take_o) |=> ((flags_o & $past(flags_o & ~clr_mask_i)) == $past(flags_o & ~clr_mask_i))); // R3
   AST_W1C_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_i |=> ((flags_o & $past(clr_mask_i & ~evt_i)) == '0)); // R3
   AST_LEVEL_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && LEVEL_SRC[vec_o]) |-> lvl_i[vec_o]); // R4
   AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (want[vec_o] && ((want & below) == '0))); // R5
   AST_CLI_BLOCKS_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      cli_i |-> !take_o); // R6
   AST_CLI_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      cli_i |=> !gie_o); // R6
   AST_SEI_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      sei_i |-> !take_o); // R7
   AST_SEI_EARLY_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sei_i && !retire_i && !cli_i) |=> !take_o); // R7
   AST_RETI_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      reti_i |-> !take_o); // R8
   AST_TAKE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (retire_i && gie_o)); // R9
   AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> (!gie_o && !take_o)); // R9
   AST_RESET_STATE: assert property (@(posedge clk)
      $rose(rst_n) |-> (flags_o == '0 && !gie_o && en_q == '0)); // R10
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_SRC(N_SRC), .LEVEL_SRC(LEVEL_SRC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_i      (evt_i),
   .lvl_i      (lvl_i),
   .clr_we_i   (clr_we_i),
   .clr_mask_i (clr_mask_i),
   .sei_i      (sei_i),
   .cli_i      (cli_i),
   .reti_i     (reti_i),
   .retire_i   (retire_i),
   .take_o     (take_o),
   .vec_o      (vec_o),
   .flags_o    (flags_o),
   .gie_o      (gie_o),
   .en_q       (en_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
   localparam int N = 8;
   localparam logic [N-1:0] LVL = 8'hC0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] evt_i = '0, lvl_i = '0, en_wdata_i = '0, clr_mask_i = '0;
   logic en_we_i = 1'b0, clr_we_i = 1'b0;
   logic sei_i = 1'b0, cli_i = 1'b0, reti_i = 1'b0, retire_i = 1'b0;
   logic take_o, gie_o;
   logic [2:0] vec_o;
   logic [N-1:0] flags_o;

   always #2.5 clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lvl_i(lvl_i),
      .en_we_i(en_we_i), .en_wdata_i(en_wdata_i), .clr_we_i(clr_we_i),
      .clr_mask_i(clr_mask_i), .sei_i(sei_i), .cli_i(cli_i), .reti_i(reti_i),
      .retire_i(retire_i), .take_o(take_o), .vec_o(vec_o),
      .flags_o(flags_o), .gie_o(gie_o)
   );

   // staged stimulus
   logic [N-1:0] s_evt, s_lvl, s_en, s_clr;
   logic s_en_we, s_clr_we, s_sei, s_cli, s_reti, s_ret;
   // model state
   logic [N-1:0] m_flags, m_en;
   logic m_gie, m_shadow;
   // observed outputs of the last cycle
   logic o_take, o_gie;
   logic [2:0] o_vec;
   logic [N-1:0] o_flags;

   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;

   function automatic logic [2:0] lowest(logic [N-1:0] r);
      logic [2:0] v = '0;
      for (int k = N - 1; k >= 0; k--) if (r[k]) v = 3'(k);
      return v;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic clear_stage();
      s_evt = '0; s_en = '0; s_clr = '0;
      s_en_we = 0; s_clr_we = 0; s_sei = 0; s_cli = 0; s_reti = 0; s_ret = 0;
   endtask

   task automatic cyc();
      logic [N-1:0] req, fl_n;
      logic take_e;
      logic [2:0] vec_e;
      @(negedge clk);
      evt_i = s_evt; lvl_i = s_lvl; en_we_i = s_en_we; en_wdata_i = s_en;
      clr_we_i = s_clr_we; clr_mask_i = s_clr; sei_i = s_sei; cli_i = s_cli;
      reti_i = s_reti; retire_i = s_ret;
      #1;
      o_take = take_o; o_vec = vec_o; o_flags = flags_o; o_gie = gie_o;
      req = ((m_flags & ~LVL) | (s_lvl & LVL)) & m_en;
      take_e = s_ret & m_gie & ~s_cli & ~s_sei & ~s_reti & ~m_shadow & (req != '0);
      vec_e = lowest(req);
      chk("R9 take pulse", 32'(o_take), 32'(take_e));
      if (take_e) chk("R5 vector", 32'(o_vec), 32'(vec_e));
      chk("R1 flags", 32'(o_flags), 32'(m_flags));
      chk("R6 global enable", 32'(o_gie), 32'(m_gie));
      fl_n = m_flags & ~(s_clr_we ? s_clr : '0) & ~(take_e ? (N'(1) << vec_e) : '0);
      fl_n = fl_n | (s_evt & ~LVL);
      @(posedge clk);
      m_flags = fl_n;
      if (s_en_we) m_en = s_en;
      if (s_cli) m_gie = 0; else if (take_e) m_gie = 0; else if (s_sei | s_reti) m_gie = 1;
      if ((s_sei | s_reti) && !s_ret) m_shadow = 1; else if (s_ret) m_shadow = 0;
      clear_stage();
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R9 watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      clear_stage(); s_lvl = '0;
      m_flags = '0; m_en = '0; m_gie = 0; m_shadow = 0;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R10 reset flags", 32'(flags_o), 0);
      chk("R10 reset gie", 32'(gie_o), 0);
      chk("R10 reset take", 32'(take_o), 0);
      rst_n = 1'b1;

      // local enables start cleared: level lines high, enable global, no take
      s_lvl = LVL; s_sei = 1; s_ret = 1; cyc();
      s_ret = 1; cyc(); chk("R10 enables cleared", 32'(o_take), 0);
      s_lvl = '0; s_cli = 1; cyc();

      // event against clear, zero bits keep flag
      s_evt = 8'h04; cyc();
      s_evt = 8'h04; s_clr_we = 1; s_clr = 8'h04; cyc();
      s_clr_we = 1; s_clr = 8'h01; cyc(); chk("R1 event beats clear", 32'(o_flags), 32'h04);
      s_clr_we = 1; s_clr = 8'h04; cyc(); chk("R3 zero bit keeps", 32'(o_flags), 32'h04);
      cyc(); chk("R3 one bit clears", 32'(o_flags), 0);

      // two pending, served in order with shadows
      s_en_we = 1; s_en = 8'h7F; s_evt = 8'h12; cyc();
      s_sei = 1; s_ret = 1; cyc(); chk("R7 strobe cycle", 32'(o_take), 0);
      s_ret = 1; cyc();
      chk("R5 first take", 32'(o_take), 1); chk("R5 first vector", 32'(o_vec), 1);
      s_ret = 1; cyc();
      chk("R9 gie cleared", 32'(o_take), 0); chk("R2 flag acked", 32'(o_flags), 32'h10);
      s_reti = 1; s_ret = 1; cyc(); chk("R8 return shadow", 32'(o_take), 0);
      s_ret = 1; cyc();
      chk("R5 second take", 32'(o_take), 1); chk("R5 second vector", 32'(o_vec), 4);

      // enable strobe ahead of its own retire
      s_evt = 8'h08; cyc();
      s_sei = 1; cyc();
      s_ret = 1; cyc(); chk("R7 shadow retire", 32'(o_take), 0);
      s_ret = 1; cyc();
      chk("R7 after shadow", 32'(o_take), 1); chk("R7 vector", 32'(o_vec), 3);

      // disable on a boundary with a pending flag
      s_evt = 8'h01; s_sei = 1; s_ret = 1; cyc();
      s_ret = 1; s_cli = 1; cyc(); chk("R6 same cycle", 32'(o_take), 0);
      s_ret = 1; cyc();
      chk("R6 stays off", 32'(o_take), 0); chk("R6 gie low", 32'(o_gie), 0);
      s_clr_we = 1; s_clr = 8'h01; cyc();

      // level source
      s_lvl = 8'h40; cyc(); chk("R4 no flag", 32'(o_flags), 0);
      s_lvl = '0; s_sei = 1; s_ret = 1; cyc();
      s_ret = 1; cyc(); chk("R4 gone before enable", 32'(o_take), 0);
      s_lvl = 8'h40; s_ret = 1; cyc();
      chk("R4 level take", 32'(o_take), 1); chk("R4 level vector", 32'(o_vec), 6);
      s_lvl = '0; s_en_we = 1; s_en = '0; s_cli = 1; cyc();

      // random traffic
      for (int t = 0; t < 3000; t++) begin
         if ($urandom % 4 == 0) s_evt = N'($urandom);
         if ($urandom % 8 == 0) s_lvl = N'($urandom);
         s_en_we  = ($urandom % 16 == 0); s_en = N'($urandom);
         s_clr_we = ($urandom % 6 == 0);  s_clr = N'($urandom);
         s_sei  = ($urandom % 12 == 0);
         s_cli  = ($urandom % 25 == 0);
         s_reti = ($urandom % 15 == 0);
         s_ret  = ($urandom % 3 != 0);
         cyc();
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule